// File: doc/BRIEF.md
# Bipolar Violation Alarm Monitor

This block watches a received dual-rail bipolar line, with one rail for positive marks and one for negative marks, sampled once per bit period on the recovered line clock. In the line code a zero is sent as no pulse, and a one is sent as a pulse of the opposite polarity to the previous pulse. When two pulses in a row have the same polarity, the block records a bipolar violation in a sticky status flag. The flag drives an active-high interrupt, which passes only when both a per-source enable and a group-level enable are set.

A small host register port gives access to four byte-wide registers: the group enable, the status, the per-source enable and a clear-mode control. The clear-mode bit selects how the sticky flag is cleared. In one mode, reading the status register clears it. In the other mode, the host writes a one to the flag's bit. The status register also shows a remote (yellow) alarm input as a read-only bit.

Top module: `bpv_alarm_mon`

## Requirements
- R1: After reset the polarity memory holds "no previous mark". The first valid mark of either polarity never flags a violation.
- R2: Marks that alternate in polarity never flag a violation, with or without no-pulse periods between them.
- R3: Two consecutive valid marks of the same polarity set status bit 3 (status register, address 0x0B02). No-pulse periods between the two marks do not matter. The bit is visible on the cycle after the second mark is sampled.
- R4: A period with both rails high is invalid. It never flags a violation and leaves the polarity memory unchanged.
- R5: Once set, status bit 3 stays set until the host clears it, whatever line activity follows.
- R6: `irq` is high exactly when status bit 3, source-enable bit 3 (address 0x0B03) and group-enable bit 1 (address 0x0B01) are all 1.
- R7: With control bit 0 (address 0x0B04) at 1, a read of the status register returns the flag as it was and clears it at the same edge.
- R8: With control bit 0 at 0, reads do not clear the flag. A write of 1 to status bit 3 clears it, and a write of 0 to that bit has no effect.
- R9: A violation in the same cycle as a clear leaves status bit 3 set.
- R10: Status bit 5 shows the `remote_alarm` input at the time of the read. Writes do not change it.
- R11: After reset all registers and `irq` are 0. The enable and control registers read back the written byte. Read data appears on the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered line clock, also used for host access |
| rst | input | 1 | Synchronous active-high reset |
| line_pos | input | 1 | Positive-mark rail |
| line_neg | input | 1 | Negative-mark rail |
| remote_alarm | input | 1 | Remote alarm state, reported on status bit 5 |
| host_sel | input | 1 | Register access strobe, one cycle per access |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_addr | input | 16 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Registered read data |
| irq | output | 1 | Active-high violation interrupt |

## Verification
A mark sampled at a clock edge updates the sticky flag and `irq` at that same edge. The bench therefore drives every rail symbol half a period before an edge and samples `irq` or reads the status half a period after it. Read data is registered, so it is taken at the falling edge after the strobe's rising edge, and a read-to-clear takes effect at that same edge. Because of this, the next read shows the cleared flag. The collision case puts a read strobe and a violating mark on the same edge, then confirms on two further reads that the flag survived one clear and fell on the next.

// File: rtl/bpv_pkg.sv
package bpv_pkg;

    localparam int HOST_AW = 16;
    localparam int HOST_DW = 8;

    typedef enum logic [1:0] {
        POL_NONE = 2'd0,
        POL_POS  = 2'd1,
        POL_NEG  = 2'd2
    } pol_e;

    typedef struct packed {
        logic pos;
        logic neg;
    } rail_t;

    typedef struct packed {
        logic               rd;
        logic               wr;
        logic [HOST_AW-1:0] addr;
        logic [HOST_DW-1:0] data;
    } host_req_t;

    function automatic logic is_mark(rail_t r);
        return r.pos ^ r.neg;
    endfunction

    function automatic pol_e pol_of(rail_t r);
        return r.pos ? POL_POS : POL_NEG;
    endfunction

endpackage

// File: rtl/bpv_line_watch.sv
module bpv_line_watch
    import bpv_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  rail_t rail,
    output logic  viol,
    output pol_e  last_pol
);
    pol_e pol_q;
    pol_e pol_d;
    logic mark;
    pol_e cur;

    always_comb begin
        mark  = is_mark(rail);
        cur   = pol_of(rail);
        viol  = mark && (pol_q != POL_NONE) && (pol_q == cur);
        pol_d = mark ? cur : pol_q;
    end

    always_ff @(posedge clk) begin
        if (rst) pol_q <= POL_NONE;
        else     pol_q <= pol_d;
    end

    assign last_pol = pol_q;
endmodule

// File: rtl/bpv_sticky_flag.sv
module bpv_sticky_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic q
);
    logic q_r;

    always_ff @(posedge clk) begin
        if (rst) q_r <= 1'b0;
        else     q_r <= set_i | (q_r & ~clr_i);
    end

    assign q = q_r;
endmodule

// File: rtl/bpv_host_regs.sv
module bpv_host_regs
    import bpv_pkg::*;
#(
    parameter logic [HOST_AW-1:0] GRP_EN_ADDR = 16'h0B01,
    parameter logic [HOST_AW-1:0] STAT_ADDR   = 16'h0B02,
    parameter logic [HOST_AW-1:0] SRC_EN_ADDR = 16'h0B03,
    parameter logic [HOST_AW-1:0] CTRL_ADDR   = 16'h0B04,
    parameter int                 VIOL_BIT    = 3,
    parameter int                 YEL_BIT     = 5,
    parameter int                 GRP_BIT     = 1,
    parameter int                 MODE_BIT    = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  host_req_t          req,
    input  logic               sticky,
    input  logic               remote_alarm,
    output logic [HOST_DW-1:0] rdata,
    output logic               src_en,
    output logic               grp_en,
    output logic               clr,
    output logic               rc_mode
);
    localparam int NREG = 3;

    logic [HOST_DW-1:0] regs_q [NREG];
    logic [HOST_DW-1:0] stat_word;
    logic [HOST_DW-1:0] rdata_q;
    logic [HOST_AW-1:0] reg_addr [NREG];

    assign reg_addr[0] = GRP_EN_ADDR;
    assign reg_addr[1] = SRC_EN_ADDR;
    assign reg_addr[2] = CTRL_ADDR;

    for (genvar g = 0; g < NREG; g++) begin : g_rw
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[g] <= '0;
            else if (req.wr && req.addr == reg_addr[g])
                regs_q[g] <= req.data;
        end
    end

    assign grp_en  = regs_q[0][GRP_BIT];
    assign src_en  = regs_q[1][VIOL_BIT];
    assign rc_mode = regs_q[2][MODE_BIT];

    always_comb begin
        stat_word           = '0;
        stat_word[VIOL_BIT] = sticky;
        stat_word[YEL_BIT]  = remote_alarm;
    end

    always_comb begin
        clr = 1'b0;
        if (req.addr == STAT_ADDR) begin
            if (rc_mode) clr = req.rd;
            else         clr = req.wr && req.data[VIOL_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
        end else if (req.rd) begin
            if (req.addr == STAT_ADDR)        rdata_q <= stat_word;
            else if (req.addr == reg_addr[0]) rdata_q <= regs_q[0];
            else if (req.addr == reg_addr[1]) rdata_q <= regs_q[1];
            else if (req.addr == reg_addr[2]) rdata_q <= regs_q[2];
            else                              rdata_q <= '0;
        end
    end

    assign rdata = rdata_q;
endmodule

// File: rtl/bpv_alarm_mon.sv
module bpv_alarm_mon
    import bpv_pkg::*;
#(
    parameter logic [HOST_AW-1:0] GRP_EN_ADDR = 16'h0B01,
    parameter logic [HOST_AW-1:0] STAT_ADDR   = 16'h0B02,
    parameter logic [HOST_AW-1:0] SRC_EN_ADDR = 16'h0B03,
    parameter logic [HOST_AW-1:0] CTRL_ADDR   = 16'h0B04
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               line_pos,
    input  logic               line_neg,
    input  logic               remote_alarm,
    input  logic               host_sel,
    input  logic               host_wr,
    input  logic [HOST_AW-1:0] host_addr,
    input  logic [HOST_DW-1:0] host_wdata,
    output logic [HOST_DW-1:0] host_rdata,
    output logic               irq
);
    rail_t     rail;
    host_req_t req;
    pol_e      last_pol;
    logic      viol_evt;
    logic      clr_evt;
    logic      sticky_q;
    logic      src_en;
    logic      grp_en;
    logic      rc_mode;

    assign rail.pos = line_pos;
    assign rail.neg = line_neg;
    assign req.rd   = host_sel & ~host_wr;
    assign req.wr   = host_sel & host_wr;
    assign req.addr = host_addr;
    assign req.data = host_wdata;

    bpv_line_watch u_watch (
        .clk      (clk),
        .rst      (rst),
        .rail     (rail),
        .viol     (viol_evt),
        .last_pol (last_pol)
    );

    bpv_sticky_flag u_flag (
        .clk   (clk),
        .rst   (rst),
        .set_i (viol_evt),
        .clr_i (clr_evt),
        .q     (sticky_q)
    );

    bpv_host_regs #(
        .GRP_EN_ADDR (GRP_EN_ADDR),
        .STAT_ADDR   (STAT_ADDR),
        .SRC_EN_ADDR (SRC_EN_ADDR),
        .CTRL_ADDR   (CTRL_ADDR)
    ) u_regs (
        .clk          (clk),
        .rst          (rst),
        .req          (req),
        .sticky       (sticky_q),
        .remote_alarm (remote_alarm),
        .rdata        (host_rdata),
        .src_en       (src_en),
        .grp_en       (grp_en),
        .clr          (clr_evt),
        .rc_mode      (rc_mode)
    );

    assign irq = sticky_q & src_en & grp_en;
endmodule

// File: rtl/bpv_alarm_mon_sva.sv
module bpv_alarm_mon_sva (
    input logic       clk,
    input logic       rst,
    input logic       line_pos,
    input logic       line_neg,
    input logic [1:0] last_pol,
    input logic       viol_evt,
    input logic       clr_evt,
    input logic       sticky_q,
    input logic       src_en,
    input logic       grp_en,
    input logic       irq
);
    // R1
    first_mark_chk: assert property (@(posedge clk) disable iff (rst)
        (last_pol == 2'd0) |-> !viol_evt);
    // R3
    viol_sets_chk: assert property (@(posedge clk) disable iff (rst)
        viol_evt |=> sticky_q);
    // R4
    invalid_no_viol_chk: assert property (@(posedge clk) disable iff (rst)
        (line_pos && line_neg) |-> !viol_evt);
    // R4
    invalid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (line_pos && line_neg) |=> $stable(last_pol));
    // R5
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sticky_q && !clr_evt) |=> sticky_q);
    // R6
    irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (sticky_q && src_en && grp_en));
    // R8
    clear_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_evt && !viol_evt) |=> !sticky_q);
    // R9
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (viol_evt && clr_evt) |=> sticky_q);
endmodule

bind bpv_alarm_mon bpv_alarm_mon_sva u_sva (
    .clk      (clk),
    .rst      (rst),
    .line_pos (line_pos),
    .line_neg (line_neg),
    .last_pol (last_pol),
    .viol_evt (viol_evt),
    .clr_evt  (clr_evt),
    .sticky_q (sticky_q),
    .src_en   (src_en),
    .grp_en   (grp_en),
    .irq      (irq)
);

// File: tb/bpv_alarm_mon_tb.sv
module bpv_alarm_mon_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] A_GRP  = 16'h0B01;
    localparam logic [15:0] A_STAT = 16'h0B02;
    localparam logic [15:0] A_SRC  = 16'h0B03;
    localparam logic [15:0] A_CTRL = 16'h0B04;
    localparam int WATCHDOG = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        line_pos = 1'b0;
    logic        line_neg = 1'b0;
    logic        remote_alarm = 1'b0;
    logic        host_sel = 1'b0;
    logic        host_wr = 1'b0;
    logic [15:0] host_addr = '0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        irq;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [7:0] d;

    always #(CLK_PERIOD/2) clk = ~clk;

    bpv_alarm_mon u_dut (
        .clk(clk), .rst(rst), .line_pos(line_pos), .line_neg(line_neg),
        .remote_alarm(remote_alarm), .host_sel(host_sel), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        line_pos = 1'b0; line_neg = 1'b0; host_sel = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr_reg(input logic [15:0] a, input logic [7:0] v);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_addr = a; host_wdata = v;
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [15:0] a, output logic [7:0] v);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b0; host_addr = a;
        @(negedge clk);
        host_sel = 1'b0;
        v = host_rdata;
    endtask

    task automatic sym(input logic p, input logic n);
        @(negedge clk);
        line_pos = p; line_neg = n;
        @(negedge clk);
        line_pos = 1'b0; line_neg = 1'b0;
    endtask

    task automatic enable_all(input logic rc);
        wr_reg(A_GRP, 8'h02);
        wr_reg(A_SRC, 8'h08);
        wr_reg(A_CTRL, {7'd0, rc});
    endtask

    task automatic t_reset();
        chk("R11 irq after reset", {7'd0, irq}, 8'h00);
        rd_reg(A_GRP, d);  chk("R11 group enable reset", d, 8'h00);
        rd_reg(A_SRC, d);  chk("R11 source enable reset", d, 8'h00);
        rd_reg(A_CTRL, d); chk("R11 control reset", d, 8'h00);
        rd_reg(A_STAT, d); chk("R11 status reset", d, 8'h00);
    endtask

    task automatic t_readback();
        wr_reg(A_GRP, 8'hA5); rd_reg(A_GRP, d); chk("R11 group readback", d, 8'hA5);
        wr_reg(A_SRC, 8'h5A); rd_reg(A_SRC, d); chk("R11 source readback", d, 8'h5A);
        wr_reg(A_CTRL, 8'h3C); rd_reg(A_CTRL, d); chk("R11 control readback", d, 8'h3C);
    endtask

    task automatic t_first_mark();
        do_reset(); enable_all(1'b0);
        sym(1'b1, 1'b0);
        chk("R1 first positive mark", {7'd0, irq}, 8'h00);
        do_reset(); enable_all(1'b0);
        sym(1'b0, 1'b1);
        rd_reg(A_STAT, d);
        chk("R1 first negative mark", d, 8'h00);
    endtask

    task automatic t_alternate();
        do_reset(); enable_all(1'b0);
        sym(1'b1, 1'b0); sym(1'b0, 1'b1);
        repeat (3) @(negedge clk);
        sym(1'b1, 1'b0); sym(1'b0, 1'b1); sym(1'b1, 1'b0);
        chk("R2 alternating irq", {7'd0, irq}, 8'h00);
        rd_reg(A_STAT, d);
        chk("R2 alternating status", d, 8'h00);
    endtask

    task automatic t_violation_sticky();
        do_reset(); enable_all(1'b0);
        sym(1'b0, 1'b1);
        repeat (4) @(negedge clk);
        @(negedge clk); line_neg = 1'b1;
        chk("R3 irq before edge", {7'd0, irq}, 8'h00);
        @(negedge clk); line_neg = 1'b0;
        chk("R3 irq one edge after second mark", {7'd0, irq}, 8'h01);
        rd_reg(A_STAT, d);
        chk("R3 status bit 3", d, 8'h08);
        sym(1'b1, 1'b0); sym(1'b0, 1'b1);
        repeat (20) @(negedge clk);
        chk("R5 flag held", {7'd0, irq}, 8'h01);
    endtask

    task automatic t_irq_mask();
        wr_reg(A_GRP, 8'h00);
        chk("R6 group enable off", {7'd0, irq}, 8'h00);
        wr_reg(A_GRP, 8'h02);
        chk("R6 both enables on", {7'd0, irq}, 8'h01);
        wr_reg(A_SRC, 8'h00);
        chk("R6 source enable off", {7'd0, irq}, 8'h00);
        wr_reg(A_SRC, 8'h08);
    endtask

    task automatic t_write_clear();
        wr_reg(A_STAT, 8'h00);
        chk("R8 write of zero keeps flag", {7'd0, irq}, 8'h01);
        rd_reg(A_STAT, d); rd_reg(A_STAT, d);
        chk("R8 reads do not clear", d, 8'h08);
        wr_reg(A_STAT, 8'h08);
        chk("R8 write one clears irq", {7'd0, irq}, 8'h00);
        rd_reg(A_STAT, d);
        chk("R8 status cleared", d, 8'h00);
    endtask

    task automatic t_read_clear();
        do_reset(); enable_all(1'b1);
        sym(1'b1, 1'b0); sym(1'b1, 1'b0);
        rd_reg(A_STAT, d);
        chk("R7 read returns set flag", d, 8'h08);
        chk("R7 irq cleared by read", {7'd0, irq}, 8'h00);
        rd_reg(A_STAT, d);
        chk("R7 next read clear", d, 8'h00);
    endtask

    task automatic t_collision();
        do_reset(); enable_all(1'b1);
        sym(1'b1, 1'b0); sym(1'b1, 1'b0);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b0; host_addr = A_STAT; line_pos = 1'b1;
        @(negedge clk);
        host_sel = 1'b0; line_pos = 1'b0;
        chk("R9 colliding read data", host_rdata, 8'h08);
        chk("R9 flag survives clear", {7'd0, irq}, 8'h01);
        rd_reg(A_STAT, d);
        chk("R9 second read still set", d, 8'h08);
        rd_reg(A_STAT, d);
        chk("R9 third read clear", d, 8'h00);
    endtask

    task automatic t_invalid();
        do_reset(); enable_all(1'b0);
        sym(1'b1, 1'b1); sym(1'b1, 1'b0);
        chk("R4 invalid then first mark", {7'd0, irq}, 8'h00);
        sym(1'b1, 1'b1); sym(1'b0, 1'b1);
        chk("R4 invalid keeps positive memory", {7'd0, irq}, 8'h00);
        sym(1'b1, 1'b1); sym(1'b0, 1'b1);
        chk("R4 invalid keeps negative memory", {7'd0, irq}, 8'h01);
    endtask

    task automatic t_yellow();
        do_reset(); enable_all(1'b0);
        remote_alarm = 1'b1;
        rd_reg(A_STAT, d);
        chk("R10 remote alarm shown", d, 8'h20);
        wr_reg(A_STAT, 8'h00);
        rd_reg(A_STAT, d);
        chk("R10 write does not change bit 5", d, 8'h20);
        remote_alarm = 1'b0;
        wr_reg(A_STAT, 8'h20);
        rd_reg(A_STAT, d);
        chk("R10 bit 5 follows input", d, 8'h00);
    endtask

    initial begin
        do_reset();
        t_reset();
        t_readback();
        t_first_mark();
        t_alternate();
        t_violation_sticky();
        t_irq_mask();
        t_write_clear();
        t_read_clear();
        t_collision();
        t_invalid();
        t_yellow();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG) begin
                total++; bad++;
                $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WATCHDOG);
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end
endmodule